// File: doc/BRIEF.md
# Grouped external interrupt controller

This block gathers 28 asynchronous external interrupt lines into four summary interrupt requests. Each line is first brought into the clock domain, then checked for a programmable trigger condition: one of two levels, or a rising, falling or either edge. When the condition is seen, the line's bit in a latched pending word is set. A per-line mask gates whether a pending bit reaches its summary output. The four summary outputs cover fixed, uneven groups of lines.

Software uses a small word-addressed register port with four registers. Two trigger-configuration words hold one 3-bit field for each pair of adjacent lines. The other two are a mask word and a pending word. Pending bits are cleared by writing ones. Reads of the pending word return the raw latched state, whatever the mask holds. A typical handler reads the pending word, services the unmasked lines of the group that fired, and writes those bits back as ones.

Top module: `ext_irq_grouper`

## Requirements
- R1: After reset, the mask word reads 0x0FFFFFFF, the pending word reads 0, trigger word 0 reads 0x77777777, trigger word 1 reads 0x00777777, and all four summary outputs are low.
- R2: Each line passes through a two-flop synchroniser. A change on a pin that causes a detection shows in the pending word after the third rising clock edge following the change, and not after the second.
- R3: Trigger code 3'b100 sets pending on a rising edge, 3'b010 on a falling edge and 3'b110 on either edge. Codes 3'b011, 3'b101 and 3'b111 never set pending.
- R4: Code 3'b000 (low level) and code 3'b001 (high level) set pending on every cycle in which the synchronised level matches. A write-one clear does not take effect while that level persists.
- R5: Lines 0 to 15 use trigger word 0 (word offset 0) and lines 16 to 27 use trigger word 1 (word offset 1). The field for line n occupies bits [o+2:o], with o = ((n mod 16) div 2) * 4, so lines 2k and 2k+1 share one field.
- R6: Writing the pending word (offset 3) clears each pending bit written as 1 and leaves the bits written as 0 unchanged.
- R7: A mask bit (mask word, offset 2) at 1 keeps its line out of the summary outputs without stopping the pending bit from latching. Clearing the mask bit lets a line that is already pending drive its output in the same cycle.
- R8: Output bit 0 is the OR of the pending and unmasked lines 0 to 3. Bit 1 covers lines 4 to 11, bit 2 covers lines 12 to 19 and bit 3 covers lines 20 to 27.
- R9: Positions with no line or field behind them read 0 and ignore writes: mask and pending bits 31:28, bit 3 of every trigger nibble, and trigger word 1 bits 31:24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 28 | Asynchronous external interrupt lines |
| bus_we | input | 1 | Register write strobe, taken on the rising clock edge |
| bus_addr | input | 2 | Word offset: 0 trigger word 0, 1 trigger word 1, 2 mask, 3 pending |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| grp_irq | output | 4 | Summary interrupt requests, one per line group |

## Verification
Results arrive at three different times. A pin change reaches the pending word after three rising edges: two synchroniser flops, then the pending flop that sits behind the detector. A register write takes effect at the edge that samples it. Summary outputs and read data follow the registers with no further delay. The bench drives pins and bus signals on falling edges and samples one falling edge after the rising edge where a result is due. For each pin change it also samples one edge earlier and requires the old value there, so a design that is one cycle early is reported.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  localparam int FIELD_W        = 3;
  localparam int FIELD_STRIDE   = 4;
  localparam int LINES_PER_WORD = 16;
  localparam int LINES_PER_FLD  = 2;
  localparam int GROUPS         = 4;

  typedef enum logic [2:0] {
    TRIG_LOW  = 3'b000,
    TRIG_HIGH = 3'b001,
    TRIG_FALL = 3'b010,
    TRIG_RISE = 3'b100,
    TRIG_BOTH = 3'b110,
    TRIG_OFF  = 3'b111
  } trig_e;

  // Bit offset of a line's trigger field inside its configuration word.
  function automatic int field_lsb(input int line);
    return ((line % LINES_PER_WORD) / LINES_PER_FLD) * FIELD_STRIDE;
  endfunction

  // Writable bits of a configuration word holding nf fields.
  function automatic logic [31:0] field_mask(input int nf);
    logic [31:0] m;
    m = '0;
    for (int f = 0; f < nf; f++) m |= 32'((1 << FIELD_W) - 1) << (f * FIELD_STRIDE);
    return m;
  endfunction

  // First line of group g; g == GROUPS gives the line count.
  function automatic int grp_bound(input int g);
    case (g)
      0:       return 0;
      1:       return 4;
      2:       return 12;
      3:       return 20;
      default: return 28;
    endcase
  endfunction

  // Trigger condition from the current and previous synchronised sample.
  function automatic logic trig_hit(input logic [2:0] code, input logic cur, input logic prev);
    case (code)
      TRIG_LOW:  return !cur;
      TRIG_HIGH: return cur;
      TRIG_FALL: return prev && !cur;
      TRIG_RISE: return !prev && cur;
      TRIG_BOTH: return prev ^ cur;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int W      = 28,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[STAGES-2:0], d_async};
  end

  assign q_sync = stg_q[STAGES-1];

  // R2
  sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q_sync) |-> q_sync == $past(stg_q[STAGES-2]));

endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import eirq_pkg::*;
#(
  parameter int W = 28
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [W-1:0]              samp,
  input  logic [W-1:0][FIELD_W-1:0] code,
  output logic [W-1:0]              hit
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= samp;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    assign hit[i] = trig_hit(code[i], samp[i], prev_q[i]);
  end

endmodule

// File: rtl/ext_irq_grouper.sv
module ext_irq_grouper
  import eirq_pkg::*;
#(
  parameter int NUM_LINES   = 28,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_pin,
  input  logic                 bus_we,
  input  logic [1:0]           bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [GROUPS-1:0]    grp_irq
);

  localparam int W1_LINES = NUM_LINES - LINES_PER_WORD;
  localparam int W0_FLDS  = LINES_PER_WORD / LINES_PER_FLD;
  localparam int W1_FLDS  = (W1_LINES + LINES_PER_FLD - 1) / LINES_PER_FLD;
  localparam logic [DATA_W-1:0] W0_MASK = DATA_W'(field_mask(W0_FLDS));
  localparam logic [DATA_W-1:0] W1_MASK = DATA_W'(field_mask(W1_FLDS));
  localparam int PAD_W = DATA_W - NUM_LINES;

  localparam logic [1:0] A_TRIG0 = 2'd0;
  localparam logic [1:0] A_TRIG1 = 2'd1;
  localparam logic [1:0] A_MASK  = 2'd2;
  localparam logic [1:0] A_PEND  = 2'd3;

  logic [DATA_W-1:0]    trig0_q, trig1_q;
  logic [NUM_LINES-1:0] mask_q, pend_q;
  logic [NUM_LINES-1:0] samp, hit, live;
  logic [NUM_LINES-1:0][FIELD_W-1:0] line_code;
  logic                 wr_trig0, wr_trig1, wr_mask, wr_pend;
  logic [NUM_LINES-1:0] clr_vec;

  eirq_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(irq_pin), .q_sync(samp)
  );

  eirq_detect #(.W(NUM_LINES)) u_detect (
    .clk(clk), .rst_n(rst_n), .samp(samp), .code(line_code), .hit(hit)
  );

  // Field selection: two adjacent lines read the same field.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_code
    localparam int LSB = field_lsb(i);
    if (i < LINES_PER_WORD) begin : g_w0
      assign line_code[i] = trig0_q[LSB +: FIELD_W];
    end else begin : g_w1
      assign line_code[i] = trig1_q[LSB +: FIELD_W];
    end
  end

  assign wr_trig0 = bus_we && (bus_addr == A_TRIG0);
  assign wr_trig1 = bus_we && (bus_addr == A_TRIG1);
  assign wr_mask  = bus_we && (bus_addr == A_MASK);
  assign wr_pend  = bus_we && (bus_addr == A_PEND);
  assign clr_vec  = wr_pend ? bus_wdata[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig0_q <= W0_MASK;
      trig1_q <= W1_MASK;
      mask_q  <= '1;
      pend_q  <= '0;
    end else begin
      if (wr_trig0) trig0_q <= bus_wdata & W0_MASK;
      if (wr_trig1) trig1_q <= bus_wdata & W1_MASK;
      if (wr_mask)  mask_q  <= bus_wdata[NUM_LINES-1:0];
      pend_q <= (pend_q & ~clr_vec) | hit;   // detection beats clear
    end
  end

  always_comb begin
    case (bus_addr)
      A_TRIG0: bus_rdata = trig0_q;
      A_TRIG1: bus_rdata = trig1_q;
      A_MASK:  bus_rdata = {{PAD_W{1'b0}}, mask_q};
      default: bus_rdata = {{PAD_W{1'b0}}, pend_q};
    endcase
  end

  assign live = pend_q & ~mask_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int LO = grp_bound(g);
    localparam int HI = grp_bound(g + 1) - 1;
    assign grp_irq[g] = |live[HI:LO];
  end

  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && hit == '0) |=> (pend_q & $past(bus_wdata[NUM_LINES-1:0])) == '0);

  // R2
  pend_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q & ~$past(pend_q) & ~$past(hit)) == '0);

  // R7
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> grp_irq == '0);

  // R8
  idle_groups_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> grp_irq == '0);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_lvl_chk
    // R4
    level_high_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_code[i] == TRIG_HIGH && samp[i]) |=> pend_q[i]);
  end

endmodule

// File: tb/ext_irq_grouper_bench.sv
`timescale 1ns/1ps
module ext_irq_grouper_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] pins = '0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  grp_irq;

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  ext_irq_grouper u_ext_irq_grouper (
    .clk(clk), .rst_n(rst_n), .irq_pin(pins), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .grp_irq(grp_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] grp_of(input int line);
    return 4'(1 << ((line + 4) / 8));
  endfunction

  logic [31:0] v;

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);

    // R1 reset state
    rd(2'd0, v); chk("R1 trig0", v, 32'h77777777);
    rd(2'd1, v); chk("R1 trig1", v, 32'h00777777);
    rd(2'd2, v); chk("R1 mask", v, 32'h0FFFFFFF);
    rd(2'd3, v); chk("R1 pend", v, 32'h0);
    chk("R1 grp", {28'h0, grp_irq}, 32'h0);

    // Sweep every line with rising trigger, all unmasked
    wr(2'd0, 32'h44444444);
    wr(2'd1, 32'h00444444);
    wr(2'd2, 32'h0);
    for (int l = 0; l < 28; l++) begin
      pins[l] = 1'b1;
      settle(2);
      rd(2'd3, v); chk($sformatf("R2 early line %0d", l), v, 32'h0);
      settle(1);
      rd(2'd3, v); chk($sformatf("R2 due line %0d", l), v, 32'(1) << l);
      chk($sformatf("R8 group line %0d", l), {28'h0, grp_irq}, {28'h0, grp_of(l)});
      pins[l] = 1'b0;
      settle(3);
      rd(2'd3, v); chk($sformatf("R3 fall ignored line %0d", l), v, 32'(1) << l);
      wr(2'd3, 32'(1) << l);
      rd(2'd3, v); chk($sformatf("R6 clear line %0d", l), v, 32'h0);
    end

    // Every code on the pair 6/7 (field at bits 14:12 of word 0)
    wr(2'd0, 32'h77777777);
    wr(2'd3, 32'hFFFFFFFF);
    for (int c = 0; c < 8; c++) begin
      logic lo, hi, ri, fa, bo, e6, e7;
      lo = (c == 0); hi = (c == 1); fa = (c == 2); ri = (c == 4); bo = (c == 6);
      wr(2'd0, (32'h77777777 & ~(32'hF << 12)) | (32'(c) << 12));
      settle(4);
      wr(2'd3, 32'hFFFFFFFF);
      e7 = lo;
      rd(2'd3, v); chk($sformatf("R4 idle low code %0d", c), 32'((v >> 6) & 3), {30'h0, lo, lo});
      pins[6] = 1'b1;
      settle(3);
      e6 = ri | bo | hi | lo;
      rd(2'd3, v); chk($sformatf("R3 rise code %0d", c), 32'((v >> 6) & 3), {30'h0, e7, e6});
      chk($sformatf("R8 grp code %0d", c), {28'h0, grp_irq}, (e6 | e7) ? 32'h2 : 32'h0);
      wr(2'd3, 32'hFFFFFFFF);
      rd(2'd3, v); chk($sformatf("R4 hold high code %0d", c), 32'((v >> 6) & 3), {30'h0, e7, hi});
      pins[6] = 1'b0;
      settle(3);
      e6 = fa | bo | lo | hi;
      rd(2'd3, v); chk($sformatf("R3 fall code %0d", c), 32'((v >> 6) & 3), {30'h0, e7, e6});
      wr(2'd3, 32'hFFFFFFFF);
      rd(2'd3, v); chk($sformatf("R4 final code %0d", c), 32'((v >> 6) & 3), {30'h0, lo, lo});
    end
    wr(2'd0, 32'h77777777);
    wr(2'd3, 32'hFFFFFFFF);
    rd(2'd3, v); chk("R4 released", v, 32'h0);

    // R5 field sharing and word split
    wr(2'd0, 32'h77777477);
    wr(2'd1, 32'h00477777);
    pins[5] = 1'b1; pins[3] = 1'b1;
    settle(3);
    rd(2'd3, v); chk("R5 line 5 shares field 2", v, 32'h20);
    pins[4] = 1'b1;
    settle(3);
    rd(2'd3, v); chk("R5 line 4 shares field 2", v, 32'h30);
    pins[27] = 1'b1;
    settle(3);
    rd(2'd3, v); chk("R5 line 27 word 1 offset 20", v, 32'h08000030);
    chk("R8 groups 1 and 3", {28'h0, grp_irq}, 32'hA);
    pins = '0;
    settle(3);
    wr(2'd3, 32'hFFFFFFFF);

    // R7 masking and R6 partial clear
    wr(2'd0, 32'h44444444);
    wr(2'd1, 32'h00444444);
    wr(2'd2, 32'h0FFFFFFF);
    pins[13] = 1'b1;
    settle(3);
    rd(2'd3, v); chk("R7 raw pending under mask", v, 32'h2000);
    chk("R7 masked group quiet", {28'h0, grp_irq}, 32'h0);
    wr(2'd2, ~(32'h1 << 13));
    chk("R7 unmask shows group 2", {28'h0, grp_irq}, 32'h4);
    pins[2] = 1'b1;
    settle(3);
    chk("R7 line 2 masked", {28'h0, grp_irq}, 32'h4);
    wr(2'd2, 32'h0FFFFFFF & ~(32'h2004));
    chk("R8 groups 0 and 2", {28'h0, grp_irq}, 32'h5);
    wr(2'd3, 32'h4);
    rd(2'd3, v); chk("R6 partial clear", v, 32'h2000);
    chk("R6 group after clear", {28'h0, grp_irq}, 32'h4);
    pins = '0;
    settle(3);
    wr(2'd3, 32'hFFFFFFFF);

    // R9 unbacked bits
    wr(2'd2, 32'hFFFFFFFF);
    rd(2'd2, v); chk("R9 mask top bits", v, 32'h0FFFFFFF);
    wr(2'd1, 32'hFFFFFFFF);
    rd(2'd1, v); chk("R9 trig1 top bits", v, 32'h00777777);
    wr(2'd0, 32'hFFFFFFFF);
    rd(2'd0, v); chk("R9 trig0 nibble bit 3", v, 32'h77777777);
    wr(2'd3, 32'hFFFFFFFF);
    rd(2'd3, v); chk("R9 pend top bits", v, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule